// File: doc/BRIEF.md
# Prescaled single-channel PWM timer

This peripheral generates one pulse-width-modulated output from a counter that climbs from zero to a programmable reload value and then wraps. A power-of-two clock divider sits in front of the counter. A compare value splits each period into an inactive part and an active part. A polarity bit picks which logic level counts as active. Software drives the block through a small register bus. Each write takes effect on the clock edge at which it is presented. Reads are combinational from the addressed register.

The bus enforces an ordering discipline. The divider and polarity settings can only be changed while the enable bit is clear. The reload and compare values can only be changed while the enable bit is set. Every accepted reload or compare write raises a sticky confirmation flag, and software clears it by writing ones to a separate clear register. The counter only starts running when a start request arrives while the block is already enabled. Clearing the enable bit stops the counter, resets it and forces the output to its inactive level.

Register map (address: contents): 0 CTRL {bit1 run, bit0 enable}; 1 SETUP {bit3 invert, bits2:0 divider shift}; 2 RELOAD; 3 MATCH; 4 FLAGS {bit1 reload written, bit0 match written}; 5 FLAGCLR (write-only, reads zero).

Top module: `lp_pwm_timer`

## Requirements
- R1: After reset every register reads zero and `pwm_out` is low.
- R2: A write to SETUP (address 1; bits 2:0 shift, bit 3 invert) is accepted only while the enable bit is clear; while enabled the write is ignored and SETUP reads back unchanged.
- R3: Writes to RELOAD (address 2) and MATCH (address 3) are accepted only while the enable bit is set; while disabled they are ignored and the registers read back unchanged.
- R4: An accepted RELOAD write sets FLAGS bit 1 and an accepted MATCH write sets FLAGS bit 0; both flags stay set until cleared.
- R5: Writing FLAGCLR (address 5) clears each FLAGS bit whose matching write-data bit is one; flags written with zero are unchanged.
- R6: A CTRL write with bit 0 and bit 1 both set, made while enable is already set, starts the counter. The counter then steps 0, 1, ..., RELOAD and wraps to 0, so the period is (RELOAD+1) ticks. CTRL bit 1 reads back as the running state.
- R7: A CTRL write with bit 0 clear clears enable and running. On the next cycle the counter and divider are back at zero and the output is at its inactive level.
- R8: The counter advances once every 2^shift clock cycles, with shift in 0..7 (ratios 1 to 128).
- R9: The output is active while running and counter > MATCH, and inactive otherwise, so a period holds (RELOAD − MATCH) active ticks. With invert = 0 active is high; with invert = 1 the waveform is inverted and the idle level is high.
- R10: A start request (CTRL bit 1) made while enable is clear does not start the counter; only the enable bit takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register (combinational) |
| pwm_out | output | 1 | PWM waveform |

## Verification
The embedded properties watch the access rules on every cycle. SETUP must not move under a write made while enabled, and RELOAD and MATCH must not move under a write made while disabled. They also check that flags rise after accepted writes and fall after a clear, that the counter is zero after any idle cycle, that it wraps after reaching the reload value, that a rise of the running state always follows an enabled state, and that the idle output equals the polarity bit. The exact timing needs the bench's cycle-by-cycle model and its counted windows. That covers the divider ratios, the active tick count per period, the phase of the waveform after a start and the inverted waveform.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  // Divider select field width; divider counter spans the largest ratio.
  localparam int SEL_W = 3;
  localparam int DIV_W = (1 << SEL_W) - 1;

  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_SETUP   = 3'd1,
    A_RELOAD  = 3'd2,
    A_MATCH   = 3'd3,
    A_FLAGS   = 3'd4,
    A_FLAGCLR = 3'd5
  } lpt_addr_e;

  typedef struct packed {
    logic             invert;
    logic [SEL_W-1:0] shift;
  } lpt_setup_t;

  // Low-order bit mask of the divider that must be all ones for a tick.
  function automatic logic [DIV_W-1:0] div_mask(input logic [SEL_W-1:0] s);
    logic [DIV_W:0] one_hot;
    one_hot = (DIV_W+1)'(1) << s;
    return DIV_W'(one_hot - (DIV_W+1)'(1));
  endfunction

  // Next counter value on a tick: wrap once the reload value is reached.
  function automatic logic [31:0] step_count(input logic [31:0] cur,
                                             input logic [31:0] top);
    return (cur >= top) ? 32'd0 : cur + 32'd1;
  endfunction
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             en_q,
  output logic             run_q,
  output lpt_setup_t       setup_q,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] match_q
);
  logic flag_match_q, flag_reload_q;

  // Named decode events
  logic wr_ctrl, wr_setup_ok, wr_reload_ok, wr_match_ok, wr_clr;
  logic wr_setup_any, wr_reload_any, wr_match_any;
  assign wr_ctrl       = wr && (addr == A_CTRL);
  assign wr_setup_any  = wr && (addr == A_SETUP);
  assign wr_reload_any = wr && (addr == A_RELOAD);
  assign wr_match_any  = wr && (addr == A_MATCH);
  assign wr_clr        = wr && (addr == A_FLAGCLR);
  assign wr_setup_ok   = wr_setup_any  && !en_q;
  assign wr_reload_ok  = wr_reload_any &&  en_q;
  assign wr_match_ok   = wr_match_any  &&  en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= wdata[0];
      run_q <= wdata[0] ? (run_q | (wdata[1] & en_q)) : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) setup_q <= '0;
    else if (wr_setup_ok) setup_q <= lpt_setup_t'(wdata[SEL_W:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      match_q  <= '0;
    end else begin
      if (wr_reload_ok) reload_q <= wdata;
      if (wr_match_ok)  match_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_match_q  <= 1'b0;
      flag_reload_q <= 1'b0;
    end else begin
      if (wr_match_ok) flag_match_q <= 1'b1;
      else if (wr_clr && wdata[0]) flag_match_q <= 1'b0;
      if (wr_reload_ok) flag_reload_q <= 1'b1;
      else if (wr_clr && wdata[1]) flag_reload_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:   rdata = CNT_W'({run_q, en_q});
      A_SETUP:  rdata = CNT_W'(setup_q);
      A_RELOAD: rdata = reload_q;
      A_MATCH:  rdata = match_q;
      A_FLAGS:  rdata = CNT_W'({flag_reload_q, flag_match_q});
      default:  rdata = '0;
    endcase
  end

  AST_SETUP_LOCKED:  assert property (@(posedge clk) disable iff (!rst_n) (wr_setup_any && en_q) |=> $stable(setup_q)); // R2
  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (wr_reload_any && !en_q) |=> $stable(reload_q)); // R3
  AST_MATCH_LOCKED:  assert property (@(posedge clk) disable iff (!rst_n) (wr_match_any && !en_q) |=> $stable(match_q)); // R3
  AST_RELOAD_FLAG:   assert property (@(posedge clk) disable iff (!rst_n) wr_reload_ok |=> flag_reload_q); // R4
  AST_MATCH_FLAG:    assert property (@(posedge clk) disable iff (!rst_n) wr_match_ok |=> flag_match_q); // R4
  AST_FLAG_CLEAR:    assert property (@(posedge clk) disable iff (!rst_n) (wr_clr && wdata[1]) |=> !flag_reload_q); // R5
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) $rose(run_q) |-> $past(en_q)); // R10
endmodule

// File: rtl/lpt_divider.sv
module lpt_divider
  import lpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] shift,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = div_mask(shift);
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (run) div_q <= div_q + DIV_W'(1);
    else          div_q <= '0;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (tick && shift != '0) |=> !tick); // R8
  AST_DIV_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !run |=> div_q == '0); // R7
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] match,
  input  logic             invert,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt_q;
  logic             active;
  logic             at_top;

  assign at_top = cnt_q >= reload;
  assign active = run && (cnt_q > match);
  assign pwm    = active ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (tick)  cnt_q <= CNT_W'(lpt_pkg::step_count(32'(cnt_q), 32'(reload)));
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !run |=> cnt_q == '0); // R7
  AST_WRAP_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) (tick && at_top) |=> cnt_q == '0); // R6
endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             pwm_out
);
  logic             en, run, tick;
  lpt_setup_t       setup;
  logic [CNT_W-1:0] reload, match;

  lpt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .en_q(en), .run_q(run), .setup_q(setup),
    .reload_q(reload), .match_q(match)
  );

  lpt_divider u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .shift(setup.shift), .tick(tick)
  );

  lpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .reload(reload),
    .match(match), .invert(setup.invert), .pwm(pwm_out)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) !run |-> pwm_out == setup.invert); // R9
  AST_RUN_IMPLIES_EN: assert property (@(posedge clk) disable iff (!rst_n) run |-> en); // R7
endmodule

// File: tb/lp_pwm_timer_test.sv
`timescale 1ns/1ps
module lp_pwm_timer_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = 3'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         pwm_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lp_pwm_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // Behavioural reference state
  bit m_en, m_run, m_inv;
  int m_shift, m_reload, m_match, m_flags, m_div, m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_run = 0; m_inv = 0; m_shift = 0;
      m_reload = 0; m_match = 0; m_flags = 0; m_div = 0; m_cnt = 0;
    end else begin
      int ratio;
      bit step;
      ratio = 1 << m_shift;
      step  = m_run && ((m_div % ratio) == ratio - 1);
      if (!m_run) m_cnt = 0;
      else if (step) m_cnt = (m_cnt >= m_reload) ? 0 : m_cnt + 1;
      m_div = m_run ? (m_div + 1) % 128 : 0;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin
            if (!bus_wdata[0]) begin m_en = 0; m_run = 0; end
            else begin
              if (bus_wdata[1] && m_en) m_run = 1;
              m_en = 1;
            end
          end
          3'd1: if (!m_en) begin m_shift = bus_wdata[2:0]; m_inv = bus_wdata[3]; end
          3'd2: if (m_en) begin m_reload = bus_wdata; m_flags = m_flags | 2; end
          3'd3: if (m_en) begin m_match = bus_wdata; m_flags = m_flags | 1; end
          3'd5: m_flags = m_flags & ~int'(bus_wdata[1:0]);
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison of the output against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp;
      exp = (m_run && (m_cnt > m_match)) ^ m_inv;
      checks++;
      if (pwm_out !== exp) begin
        errs++;
        $display("FAIL R9 per-cycle pwm_out=%0b expected %0b (cnt model %0d)", pwm_out, exp, m_cnt);
      end
    end
  end

  task automatic write_reg(input int a, input int d);
    bus_addr = 3'(a); bus_wdata = W'(d); bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic check_reg(input int a, input int exp, input string req);
    bus_addr = 3'(a);
    #1;
    checks++;
    if (bus_rdata !== W'(exp)) begin
      errs++;
      $display("FAIL %s reg %0d read %0h expected %0h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic count_high(input int n, input int exp, input string req);
    int hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    checks++;
    if (hi != exp) begin
      errs++;
      $display("FAIL %s high cycles %0d expected %0d", req, hi, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) check_reg(a, 0, "R1");
    checks++;
    if (pwm_out !== 1'b0) begin errs++; $display("FAIL R1 pwm_out=%0b expected 0", pwm_out); end

    // R3: reload/match ignored while disabled
    write_reg(2, 9);
    write_reg(3, 5);
    check_reg(2, 0, "R3");
    check_reg(3, 0, "R3");
    check_reg(4, 0, "R4");

    // R10: start without enable does nothing
    write_reg(0, 2);
    check_reg(0, 0, "R10");

    // R2: setup accepted while disabled (shift 2)
    write_reg(1, 2);
    check_reg(1, 2, "R2");

    // R10: enable plus start from disabled only enables
    write_reg(0, 3);
    check_reg(0, 1, "R10");

    // R2: setup ignored while enabled
    write_reg(1, 4'hF);
    check_reg(1, 2, "R2");

    // R3/R4: writes accepted while enabled, flags set
    write_reg(2, 9);
    check_reg(4, 2, "R4");
    write_reg(3, 5);
    check_reg(2, 9, "R3");
    check_reg(3, 5, "R3");
    check_reg(4, 3, "R4");

    // R5: clear selectively
    write_reg(5, 1);
    check_reg(4, 2, "R5");
    write_reg(5, 0);
    check_reg(4, 2, "R5");
    write_reg(5, 2);
    check_reg(4, 0, "R5");
    check_reg(5, 0, "R5");

    // R6/R8/R9: start, period 10 ticks x 4 cycles, 4 active ticks
    write_reg(0, 3);
    check_reg(0, 3, "R6");
    count_high(400, 160, "R6");

    // R7: stop
    write_reg(0, 0);
    check_reg(0, 0, "R7");
    checks++;
    if (pwm_out !== 1'b0) begin errs++; $display("FAIL R7 pwm_out=%0b expected 0", pwm_out); end

    // R9/R8: inverted, shift 0, reload 3, match 0 -> high 1 of 4 cycles
    write_reg(1, 8);
    check_reg(1, 8, "R9");
    checks++;
    if (pwm_out !== 1'b1) begin errs++; $display("FAIL R9 idle inverted pwm_out=%0b expected 1", pwm_out); end
    write_reg(0, 1);
    write_reg(2, 3);
    write_reg(3, 0);
    write_reg(0, 3);
    count_high(40, 10, "R9");

    // R8: shift 7, reload 1, match 0 -> 128 of 256 cycles active
    write_reg(0, 0);
    write_reg(1, 7);
    write_reg(0, 1);
    write_reg(2, 1);
    write_reg(3, 0);
    write_reg(0, 3);
    count_high(512, 256, "R8");

    // R7: stop mid-period, idle low, restart from phase zero
    write_reg(0, 0);
    checks++;
    if (pwm_out !== 1'b0) begin errs++; $display("FAIL R7 pwm_out=%0b expected 0", pwm_out); end
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule